// File: doc/BRIEF.md
# Serial Link Frame Formatter

This block sits between a show-ahead transmit FIFO and the symbol encoder of a serial data link. Each cycle it produces one abstract symbol. The symbols are start delimiters, data words, end delimiters, a marker for a SYNC that carries data, and IDLE fill. Payload words are packed into frames of bounded length.

Sideband levels travel inside the choice of delimiter. The three parallel-port control lines select one of eight start-delimiter variants. The overflow and not-ready status bits select one of four status end-delimiter variants. A word marked SYNC at the FIFO head closes any open frame and is then sent in a frame of its own. A remote STOP/GO indication holds back the opening of new payload frames. Data waits in the FIFO until the link may proceed.

Symbol codes on `sym_kind_o` are 5-bit values: IDLE=0, start delimiter = 1 + {pio1,pio2,dir} (codes 1..8), DATA=9, status end = 10 + {ovf,nrdy} (codes 10..13), frame end=14, SYNC-frame end=15, SYNC-with-data marker=16. The output is registered, so a symbol appears one cycle after the decision that picked it. `fifo_pop_o` is asserted in the decision cycle of each symbol that consumes the head word.

Top module: `slink_framer`

## Requirements
- R1: During and after reset, with the FIFO empty and the sideband unchanged from zero, `sym_kind_o` is IDLE (0) and `fifo_pop_o` is low.
- R2: A start delimiter has code 1 + {pio1,pio2,dir}, using the levels present in the cycle it is chosen.
- R3: When no payload frame opens and any of pio1, pio2, dir, ovf or nrdy differs from the last levels carried, a status frame is sent: a start delimiter, then the status end code 10 + {ovf,nrdy}. This happens even while STOP is signalled.
- R4: A payload frame is a start delimiter, then one DATA (9) symbol per word in FIFO order with the word on `sym_data_o`, then frame end (14) once the FIFO is empty. Exactly one pop occurs per word sent.
- R5: After MAX_WORDS DATA symbols, the frame closes with frame end (14). The remaining words go into a new frame that opens on the next cycle.
- R6: A SYNC-flagged word at the FIFO head closes an open payload frame with frame end (14) and is not consumed by that frame.
- R7: A SYNC word with its valid-data flag set is sent as a start delimiter, the marker 16, DATA with the word, then SYNC-frame end (15).
- R8: A SYNC word with its valid-data flag clear is sent as a start delimiter followed directly by SYNC-frame end (15), and the word is popped.
- R9: While `go_i` is low, no payload or SYNC frame opens and the FIFO is not popped.
- R10: A frame already open when `go_i` falls runs to its normal end.
- R11: IDLE (0) is sent whenever there is neither a frame in progress nor a frame to open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_data_i | input | DATA_W | Word at FIFO head |
| fifo_sync_i | input | 1 | Head word carries SYNC |
| fifo_dv_i | input | 1 | Head SYNC word carries valid data |
| fifo_pop_o | output | 1 | Consume head word |
| pio1_i | input | 1 | Parallel control line 1 level |
| pio2_i | input | 1 | Parallel control line 2 level |
| dir_i | input | 1 | Direction line level |
| nrdy_i | input | 1 | Not-ready status |
| ovf_i | input | 1 | FIFO overflow status |
| go_i | input | 1 | Far end has room (1=GO, 0=STOP) |
| sym_kind_o | output | 5 | Symbol code |
| sym_data_o | output | DATA_W | Word carried by a DATA symbol, else zero |

## Verification
The bench builds the block with DATA_W=16 and MAX_WORDS=4. The short frame limit lets a six-word burst cross a frame boundary, so the split into two frames, each with its own start delimiter, can be checked within a few cycles. A table walks all eight start-delimiter and all four status-end variants. Directed sequences then cover SYNC cutting a frame short, both SYNC kinds, STOP before and during a frame, and a status frame sent while STOP holds data back.

// File: rtl/slink_pkg.sv
`timescale 1ns/1ps
package slink_pkg;

  typedef logic [4:0] sym_t;

  localparam sym_t SYM_IDLE      = 5'd0;
  localparam sym_t SYM_SOF_BASE  = 5'd1;
  localparam sym_t SYM_DATA      = 5'd9;
  localparam sym_t SYM_SEOF_BASE = 5'd10;
  localparam sym_t SYM_FEOF      = 5'd14;
  localparam sym_t SYM_MEOF      = 5'd15;
  localparam sym_t SYM_SYNC_DV   = 5'd16;

  // Sideband levels carried by delimiters
  typedef struct packed {
    logic pio1;
    logic pio2;
    logic dir;
    logic ovf;
    logic nrdy;
  } side_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_SYNC_HDR,
    ST_SYNC_WORD,
    ST_SYNC_END,
    ST_STATUS
  } fsm_e;

  function automatic sym_t sof_code(side_t s);
    return SYM_SOF_BASE + {2'b00, s.pio1, s.pio2, s.dir};
  endfunction

  function automatic sym_t seof_code(side_t s);
    return SYM_SEOF_BASE + {3'b000, s.ovf, s.nrdy};
  endfunction

  function automatic logic is_sof(sym_t k);
    return (k >= SYM_SOF_BASE) && (k < SYM_DATA);
  endfunction

endpackage

// File: rtl/slink_side_track.sv
`timescale 1ns/1ps
// Holds the sideband levels last carried over the link.
module slink_side_track
  import slink_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  side_t side_i,
  input  logic  take_ctrl_i,
  input  logic  take_all_i,
  output side_t sent_o,
  output logic  differs_o
);

  side_t sent_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sent_q <= '0;
    end else if (take_all_i) begin
      sent_q <= side_i;
    end else if (take_ctrl_i) begin
      sent_q.pio1 <= side_i.pio1;
      sent_q.pio2 <= side_i.pio2;
      sent_q.dir  <= side_i.dir;
    end
  end

  assign sent_o    = sent_q;
  assign differs_o = (side_i != sent_q);

endmodule

// File: rtl/slink_len_ctr.sv
`timescale 1ns/1ps
// Counts payload words in the open frame.
module slink_len_ctr #(
  parameter int MAX_WORDS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);

  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WORDS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIMIT);

endmodule

// File: rtl/slink_sym_reg.sv
`timescale 1ns/1ps
// Output stage: one registered symbol per cycle.
module slink_sym_reg
  import slink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sym_t              kind_d_i,
  input  logic [DATA_W-1:0] data_d_i,
  output sym_t              kind_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      kind_o <= SYM_IDLE;
      data_o <= '0;
    end else begin
      kind_o <= kind_d_i;
      data_o <= data_d_i;
    end
  end

endmodule

// File: rtl/slink_framer.sv
`timescale 1ns/1ps
module slink_framer
  import slink_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_sync_i,
  input  logic              fifo_dv_i,
  output logic              fifo_pop_o,
  input  logic              pio1_i,
  input  logic              pio2_i,
  input  logic              dir_i,
  input  logic              nrdy_i,
  input  logic              ovf_i,
  input  logic              go_i,
  output logic [4:0]        sym_kind_o,
  output logic [DATA_W-1:0] sym_data_o
);

  fsm_e              st_q, st_d;
  side_t             side_now, side_sent;
  logic              side_differs_w;
  logic              take_ctrl_w, take_all_w;
  logic              len_clr_w, len_inc_w, len_full_w;
  sym_t              kind_d;
  logic [DATA_W-1:0] data_d;
  logic              pop_w;

  // named events
  logic open_payload_w;
  logic open_status_w;

  assign side_now = '{pio1: pio1_i, pio2: pio2_i, dir: dir_i, ovf: ovf_i, nrdy: nrdy_i};

  slink_side_track u_side (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .side_i     (side_now),
    .take_ctrl_i(take_ctrl_w),
    .take_all_i (take_all_w),
    .sent_o     (side_sent),
    .differs_o  (side_differs_w)
  );

  slink_len_ctr #(.MAX_WORDS(MAX_WORDS)) u_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (len_clr_w),
    .inc_i (len_inc_w),
    .full_o(len_full_w)
  );

  assign open_payload_w = (st_q == ST_IDLE) && !fifo_empty_i && go_i;
  assign open_status_w  = (st_q == ST_IDLE) && !open_payload_w && side_differs_w;

  always_comb begin
    st_d        = st_q;
    kind_d      = SYM_IDLE;
    data_d      = '0;
    pop_w       = 1'b0;
    take_ctrl_w = 1'b0;
    take_all_w  = 1'b0;
    len_clr_w   = 1'b0;
    len_inc_w   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (open_payload_w) begin
          kind_d      = sof_code(side_now);
          take_ctrl_w = 1'b1;
          len_clr_w   = 1'b1;
          st_d        = fifo_sync_i ? ST_SYNC_HDR : ST_BODY;
        end else if (open_status_w) begin
          kind_d     = sof_code(side_now);
          take_all_w = 1'b1;
          st_d       = ST_STATUS;
        end
      end
      ST_BODY: begin
        if (fifo_empty_i || fifo_sync_i || len_full_w) begin
          kind_d = SYM_FEOF;
          st_d   = ST_IDLE;
        end else begin
          kind_d    = SYM_DATA;
          data_d    = fifo_data_i;
          pop_w     = 1'b1;
          len_inc_w = 1'b1;
        end
      end
      ST_SYNC_HDR: begin
        if (fifo_dv_i) begin
          kind_d = SYM_SYNC_DV;
          st_d   = ST_SYNC_WORD;
        end else begin
          kind_d = SYM_MEOF;
          pop_w  = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_SYNC_WORD: begin
        kind_d = SYM_DATA;
        data_d = fifo_data_i;
        pop_w  = 1'b1;
        st_d   = ST_SYNC_END;
      end
      ST_SYNC_END: begin
        kind_d = SYM_MEOF;
        st_d   = ST_IDLE;
      end
      ST_STATUS: begin
        kind_d = seof_code(side_sent);
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  slink_sym_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kind_d_i(kind_d),
    .data_d_i(data_d),
    .kind_o  (sym_kind_o),
    .data_o  (sym_data_o)
  );

  assign fifo_pop_o = pop_w;

endmodule

// File: rtl/slink_framer_chk.sv
`timescale 1ns/1ps
module slink_framer_chk
  import slink_pkg::*;
#(
  parameter int MAX_WORDS = 512
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       go_i,
  input logic       fifo_empty_i,
  input logic       fifo_pop_o,
  input logic [4:0] sym_kind_o
);

  localparam int CW = $clog2(MAX_WORDS + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                    run_q <= '0;
    else if (is_sof(sym_kind_o))    run_q <= '0;
    else if (sym_kind_o == SYM_DATA) run_q <= run_q + 1'b1;
  end

  assert_pop_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  assert_pop_yields_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> (sym_kind_o == SYM_DATA) || (sym_kind_o == SYM_MEOF));

  assert_len_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(MAX_WORDS));

  assert_start_needs_go_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((sym_kind_o == SYM_DATA) || (sym_kind_o == SYM_SYNC_DV) || (sym_kind_o == SYM_MEOF))
      && is_sof($past(sym_kind_o))) |-> $past(go_i, 2));

  assert_feof_after_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_kind_o == SYM_FEOF) |-> ($past(sym_kind_o) == SYM_DATA));

  assert_meof_placement_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_kind_o == SYM_MEOF) |-> (is_sof($past(sym_kind_o)) || ($past(sym_kind_o) == SYM_DATA)));

endmodule

bind slink_framer slink_framer_chk #(.MAX_WORDS(MAX_WORDS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .go_i        (go_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_pop_o  (fifo_pop_o),
  .sym_kind_o  (sym_kind_o)
);

// File: tb/slink_framer_tb.sv
`timescale 1ns/1ps
module slink_framer_tb_top;

  localparam int DW  = 16;
  localparam int MAX = 4;

  localparam logic [4:0] K_IDLE = 5'd0, K_DATA = 5'd9, K_FEOF = 5'd14,
                         K_MEOF = 5'd15, K_SDV = 5'd16;

  // Vector table: {pio1,pio2,dir,ovf,nrdy}, expected start code, expected status end code
  localparam logic [4:0] VEC_SIDE [8] = '{5'b000_01, 5'b001_10, 5'b010_11, 5'b011_00,
                                          5'b100_01, 5'b101_10, 5'b110_11, 5'b111_00};
  localparam logic [4:0] VEC_SOF  [8] = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8};
  localparam logic [4:0] VEC_SEOF [8] = '{5'd11, 5'd12, 5'd13, 5'd10, 5'd11, 5'd12, 5'd13, 5'd10};

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [DW-1:0] m_data [64];
  logic          m_sync [64];
  logic          m_dv   [64];
  int rd = 0, wr = 0;

  logic          fifo_empty, fifo_pop, fifo_sync, fifo_dv;
  logic [DW-1:0] fifo_data;
  logic pio1 = 0, pio2 = 0, dir = 0, nrdy = 0, ovf = 0, go = 1;
  logic [4:0]    sym_kind;
  logic [DW-1:0] sym_data;

  assign fifo_empty = (rd == wr);
  assign fifo_data  = m_data[rd[5:0]];
  assign fifo_sync  = m_sync[rd[5:0]];
  assign fifo_dv    = m_dv[rd[5:0]];

  always @(posedge clk) if (rst_n && fifo_pop) rd <= rd + 1;

  slink_framer #(.DATA_W(DW), .MAX_WORDS(MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_sync_i(fifo_sync),
    .fifo_dv_i(fifo_dv), .fifo_pop_o(fifo_pop),
    .pio1_i(pio1), .pio2_i(pio2), .dir_i(dir), .nrdy_i(nrdy), .ovf_i(ovf),
    .go_i(go), .sym_kind_o(sym_kind), .sym_data_o(sym_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic push(input logic [DW-1:0] d, input logic s, input logic v);
    m_data[wr[5:0]] = d; m_sync[wr[5:0]] = s; m_dv[wr[5:0]] = v;
    wr = wr + 1;
  endtask

  task automatic check_now(input logic [4:0] k, input logic [DW-1:0] d, input string tag);
    checks++;
    if (sym_kind !== k || (k == K_DATA && sym_data !== d)) begin
      fails++;
      $display("FAIL %s: kind=%0d data=%h expected kind=%0d data=%h", tag, sym_kind, sym_data, k, d);
    end
  endtask

  task automatic expect_sym(input logic [4:0] k, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    check_now(k, d, tag);
  endtask

  task automatic expect_drained(input string tag);
    checks++;
    if (rd != wr) begin
      fails++;
      $display("FAIL %s: read=%0d expected read=%0d", tag, rd, wr);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_sync[i] = 0; m_dv[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: held in reset
    check_now(K_IDLE, '0, "R1 in reset");
    rst_n = 1;
    expect_sym(K_IDLE, '0, "R1 after reset");
    checks++;
    if (fifo_pop !== 1'b0) begin fails++; $display("FAIL R1: pop=%b expected 0", fifo_pop); end
    expect_sym(K_IDLE, '0, "R11 idle fill");

    // R2/R3: walk all delimiter variants through status frames
    for (int i = 0; i < 8; i++) begin
      {pio1, pio2, dir, ovf, nrdy} = VEC_SIDE[i];
      expect_sym(VEC_SOF[i], '0, "R2 start variant");
      expect_sym(VEC_SEOF[i], '0, "R3 status end variant");
      expect_sym(K_IDLE, '0, "R11 after status frame");
    end
    // sideband now 111, status 00 -> start code 8

    // R4: plain payload frame
    push(16'hA001, 0, 0); push(16'hA002, 0, 0);
    expect_sym(5'd8, '0, "R4 start");
    expect_sym(K_DATA, 16'hA001, "R4 word0");
    expect_sym(K_DATA, 16'hA002, "R4 word1");
    expect_sym(K_FEOF, '0, "R4 end on empty");
    expect_sym(K_IDLE, '0, "R11 after frame");
    expect_drained("R4 drained");

    // R5: frame length limit
    for (int i = 0; i < 6; i++) push(16'hB000 + DW'(i), 0, 0);
    expect_sym(5'd8, '0, "R5 start");
    for (int i = 0; i < 4; i++) expect_sym(K_DATA, 16'hB000 + DW'(i), "R5 body");
    expect_sym(K_FEOF, '0, "R5 end at limit");
    expect_sym(5'd8, '0, "R5 new frame");
    expect_sym(K_DATA, 16'hB004, "R5 second frame word0");
    expect_sym(K_DATA, 16'hB005, "R5 second frame word1");
    expect_sym(K_FEOF, '0, "R5 second frame end");

    // R6/R7: sync with data cuts the frame
    push(16'hC001, 0, 0); push(16'hC0DE, 1, 1);
    expect_sym(5'd8, '0, "R6 start");
    expect_sym(K_DATA, 16'hC001, "R6 word before sync");
    expect_sym(K_FEOF, '0, "R6 frame cut by sync");
    expect_sym(5'd8, '0, "R7 sync frame start");
    expect_sym(K_SDV, '0, "R7 data marker");
    expect_sym(K_DATA, 16'hC0DE, "R7 sync word");
    expect_sym(K_MEOF, '0, "R7 sync frame end");
    expect_sym(K_IDLE, '0, "R11 after sync");

    // R8: sync without data
    push(16'hD000, 1, 0);
    expect_sym(5'd8, '0, "R8 start");
    expect_sym(K_MEOF, '0, "R8 sync end");
    expect_sym(K_IDLE, '0, "R8 idle");
    expect_drained("R8 word consumed");

    // R9: STOP holds data
    go = 0;
    push(16'hE001, 0, 0);
    for (int i = 0; i < 3; i++) expect_sym(K_IDLE, '0, "R9 held by STOP");
    checks++;
    if (rd == wr) begin fails++; $display("FAIL R9: read=%0d expected read=%0d", rd, wr - 1); end
    // R3: status frame still sent under STOP
    ovf = 1;
    expect_sym(5'd8, '0, "R3 start under STOP");
    expect_sym(5'd12, '0, "R3 status end under STOP");
    expect_sym(K_IDLE, '0, "R9 still held");
    go = 1;
    expect_sym(5'd8, '0, "R9 start after GO");
    expect_sym(K_DATA, 16'hE001, "R9 word");
    expect_sym(K_FEOF, '0, "R9 end");

    // R10: STOP mid-frame does not cut it
    push(16'hF001, 0, 0); push(16'hF002, 0, 0); push(16'hF003, 0, 0);
    expect_sym(5'd8, '0, "R10 start");
    go = 0;
    expect_sym(K_DATA, 16'hF001, "R10 word0");
    expect_sym(K_DATA, 16'hF002, "R10 word1");
    expect_sym(K_DATA, 16'hF003, "R10 word2");
    expect_sym(K_FEOF, '0, "R10 end");
    expect_sym(K_IDLE, '0, "R11 final idle");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule